// File: doc/BRIEF.md
# Keyed NMI Aggregator with Watchdog

This block gathers six error sources into one flag word and drives a single non-maskable interrupt request. Each source latches its own flag. Once the global enable is on, a summary flag in bit 0 gathers the source flags and drives the NMI output. A second flag word, the shadow, records every flag that has ever been set. Clearing the live flags does not clear the shadow, so a handler can see the history.

Software reaches the block through a synchronous write port. A write names one of four targets: clear, force, configuration or period. The target changes only if the upper 16 bits of the write word hold that target's own unlock key. While the summary flag is set, a 16-bit NMI watchdog counter runs. If the counter reaches a programmable period before the flags are handled, the block raises a reset request.

Top module: `nmi_keyed_agg`

## Requirements
- R1: During and after reset, the flags and shadow are 0, the global enable is 0, the period is 0xFFFF, the counter is 0, and nmi_o and rst_req_o are low.
- R2: A high src_i[k] at a clock edge sets flag bit k+1. The flag stays set after the source drops.
- R3: The target codes are clear = 0, force = 1, configuration = 2 and period = 3. A clear write (wr_sel_i = 0) whose bits 31:16 equal 0x5674 clears every flag whose bit is set in bits 6:0.
- R4: A force write (wr_sel_i = 1) whose bits 31:16 equal 0x2732 sets every flag whose bit is set in bits 6:0.
- R5: A configuration write (wr_sel_i = 2) whose bits 31:16 equal 0x6789 loads bit 0 into the global enable.
- R6: A period write (wr_sel_i = 3) whose bits 31:16 equal 0x9238 loads bits 15:0 into the period.
- R7: The summary flag (bit 0, equal to nmi_o) sets on the edge after both the global enable and some source flag are registered high, or when bit 0 is forced. It is cleared only by clear bit 0.
- R8: Each shadow bit sets whenever its flag is set. A clear write does not clear it; only reset does.
- R9: The watchdog counter rises by 1 per cycle while the summary flag is set and holds once it reaches the period. It returns to 0 on the edge after the summary flag is seen low.
- R10: rst_req_o is high while the summary flag is set and the counter is at or above the period. Writing a period below the current count raises the request right after that write's edge.
- R11: A write whose key does not match its target's key leaves every register unchanged.
- R12: When a flag is set and cleared in the same cycle, it ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 2 | Write target: 0 clear, 1 force, 2 configuration, 3 period |
| wr_data_i | input | 32 | Key in bits 31:16, payload in bits 15:0 |
| src_i | input | 6 | Error sources; bit k feeds flag bit k+1 |
| flags_o | output | 7 | Live flags; bit 0 is the summary |
| shadow_o | output | 7 | Sticky shadow copy of the flags |
| glb_en_o | output | 1 | Global NMI enable |
| period_o | output | 16 | Watchdog period |
| wd_count_o | output | 16 | Watchdog counter |
| nmi_o | output | 1 | NMI request |
| rst_req_o | output | 1 | Reset request from the watchdog |

## Verification
Register state is due on the first edge after a write or a source pulse: source flags, shadow, enable and period all change there. The summary flag is due one edge later. The counter reaches k on the k-th edge after the summary flag is set, and rst_req_o follows the counter and period in the same cycle with no extra register. The bench drives its inputs on falling edges and samples one falling edge after each rising edge. Each expected value in the table and in the directed tests is placed at the edge count listed above.

// File: rtl/nmi_agg_pkg.sv
package nmi_agg_pkg;
  localparam int NUM_SRC = 6;
  localparam int CNT_W   = 16;
  localparam int DATA_W  = 32;
  localparam int KEY_W   = 16;

  typedef enum logic [1:0] {
    SEL_CLR = 2'd0,
    SEL_FRC = 2'd1,
    SEL_CFG = 2'd2,
    SEL_PRD = 2'd3
  } wr_sel_e;

  localparam logic [KEY_W-1:0] KEY_CLR = 16'h5674;
  localparam logic [KEY_W-1:0] KEY_FRC = 16'h2732;
  localparam logic [KEY_W-1:0] KEY_CFG = 16'h6789;
  localparam logic [KEY_W-1:0] KEY_PRD = 16'h9238;
endpackage

// File: rtl/nmi_key_port.sv
module nmi_key_port
  import nmi_agg_pkg::*;
#(
  parameter int NUM_FLAG = 7,
  parameter int CNT_W_P  = 16,
  parameter int DATA_W_P = 32,
  parameter int KEY_W_P  = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [1:0]          wr_sel_i,
  input  logic [DATA_W_P-1:0] wr_data_i,
  output logic [NUM_FLAG-1:0] clr_o,
  output logic [NUM_FLAG-1:0] frc_o,
  output logic                glb_en_o,
  output logic [CNT_W_P-1:0]  period_o
);
  localparam int LOW_W = DATA_W_P - KEY_W_P;

  logic [KEY_W_P-1:0] key;
  logic [LOW_W-1:0]   low;
  logic               cfg_we, prd_we;
  logic               glb_en_q;
  logic [CNT_W_P-1:0] period_q;

  assign key = wr_data_i[DATA_W_P-1 -: KEY_W_P];
  assign low = wr_data_i[LOW_W-1:0];

  always_comb begin
    clr_o  = '0;
    frc_o  = '0;
    cfg_we = 1'b0;
    prd_we = 1'b0;
    if (wr_en_i) begin
      unique case (wr_sel_e'(wr_sel_i))
        SEL_CLR: if (key == KEY_CLR) clr_o = low[NUM_FLAG-1:0];
        SEL_FRC: if (key == KEY_FRC) frc_o = low[NUM_FLAG-1:0];
        SEL_CFG: cfg_we = (key == KEY_CFG);
        SEL_PRD: prd_we = (key == KEY_PRD);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glb_en_q <= 1'b0;
      period_q <= '1;
    end else begin
      if (cfg_we) glb_en_q <= low[0];
      if (prd_we) period_q <= low[CNT_W_P-1:0];
    end
  end

  assign glb_en_o = glb_en_q;
  assign period_o = period_q;

  AST_BAD_KEY_PRD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 2'd3 && key != KEY_PRD) |=> $stable(period_q)); // R11
  AST_BAD_KEY_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 2'd2 && key != KEY_CFG) |=> $stable(glb_en_q)); // R11
  AST_ONE_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((|clr_o) && (|frc_o))); // R3
endmodule

// File: rtl/nmi_flag_bank.sv
module nmi_flag_bank #(
  parameter int NUM_SRC = 6,
  localparam int NUM_FLAG = NUM_SRC + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_SRC-1:0]  src_i,
  input  logic [NUM_FLAG-1:0] clr_i,
  input  logic [NUM_FLAG-1:0] frc_i,
  input  logic                glb_en_i,
  output logic [NUM_FLAG-1:0] flags_o,
  output logic [NUM_FLAG-1:0] shadow_o
);
  logic [NUM_FLAG-1:0] flag_q, flag_d, shadow_q;
  logic                any_src;

  assign any_src = |flag_q[NUM_FLAG-1:1];

  // set wins over clear on every bit
  assign flag_d[0] = (glb_en_i & any_src) | frc_i[0] | (flag_q[0] & ~clr_i[0]);

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    assign flag_d[k+1] = src_i[k] | frc_i[k+1] | (flag_q[k+1] & ~clr_i[k+1]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q   <= '0;
      shadow_q <= '0;
    end else begin
      flag_q   <= flag_d;
      shadow_q <= shadow_q | flag_d;
    end
  end

  assign flags_o  = flag_q;
  assign shadow_o = shadow_q;

  AST_SHADOW_COVERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q & ~shadow_q) == '0); // R8
  AST_SHADOW_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_i) |=> ((shadow_q & $past(shadow_q)) == $past(shadow_q))); // R8
  AST_SRC_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|src_i) |=> ((flag_q[NUM_FLAG-1:1] & $past(src_i)) == $past(src_i))); // R2
endmodule

// File: rtl/nmi_wd_counter.sv
module nmi_wd_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             summary_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] count_o,
  output logic             rst_req_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             at_limit;

  assign at_limit = (cnt_q >= period_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (!summary_i) cnt_q <= '0;
    else if (!at_limit)  cnt_q <= cnt_q + 1'b1;
  end

  // a period below the count trips at once
  assign rst_req_o = summary_i & at_limit;
  assign count_o   = cnt_q;

  AST_CNT_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !summary_i |=> (cnt_q == '0)); // R9
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (summary_i && $past(summary_i) && $stable(period_i) && $past(cnt_q) < period_i)
      |-> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R9
  AST_RST_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_req_o && summary_i) |=> (rst_req_o || !summary_i || !$stable(period_i))); // R10
endmodule

// File: rtl/nmi_keyed_agg.sv
module nmi_keyed_agg
  import nmi_agg_pkg::*;
#(
  parameter int NUM_SRC_P = NUM_SRC,
  parameter int CNT_W_P   = CNT_W,
  localparam int NUM_FLAG = NUM_SRC_P + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [1:0]           wr_sel_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  input  logic [NUM_SRC_P-1:0] src_i,
  output logic [NUM_FLAG-1:0]  flags_o,
  output logic [NUM_FLAG-1:0]  shadow_o,
  output logic                 glb_en_o,
  output logic [CNT_W_P-1:0]   period_o,
  output logic [CNT_W_P-1:0]   wd_count_o,
  output logic                 nmi_o,
  output logic                 rst_req_o
);
  logic [NUM_FLAG-1:0] clr, frc;

  nmi_key_port #(
    .NUM_FLAG(NUM_FLAG), .CNT_W_P(CNT_W_P), .DATA_W_P(DATA_W), .KEY_W_P(KEY_W)
  ) u_key (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .clr_o(clr), .frc_o(frc), .glb_en_o, .period_o
  );

  nmi_flag_bank #(.NUM_SRC(NUM_SRC_P)) u_flags (
    .clk_i, .rst_ni, .src_i, .clr_i(clr), .frc_i(frc),
    .glb_en_i(glb_en_o), .flags_o, .shadow_o
  );

  assign nmi_o = flags_o[0];

  nmi_wd_counter #(.CNT_W(CNT_W_P)) u_wd (
    .clk_i, .rst_ni, .summary_i(flags_o[0]), .period_i(period_o),
    .count_o(wd_count_o), .rst_req_o
  );
endmodule

// File: tb/nmi_keyed_agg_tb.sv
module nmi_keyed_agg_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_sel_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [5:0]  src_i = '0;
  logic [6:0]  flags_o, shadow_o;
  logic        glb_en_o, nmi_o, rst_req_o;
  logic [15:0] period_o, wd_count_o;

  nmi_keyed_agg u_dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(logic wr, logic [1:0] sel, logic [31:0] data, logic [5:0] src);
    wr_en_i = wr; wr_sel_i = sel; wr_data_i = data; src_i = src;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic idle();
    cyc(1'b0, 2'd0, 32'h0, 6'h0);
  endtask

  task automatic check_reset(string tag);
    chk({tag, " R1 flags"}, 32'(flags_o), 0);
    chk({tag, " R1 shadow"}, 32'(shadow_o), 0);
    chk({tag, " R1 glb_en"}, 32'(glb_en_o), 0);
    chk({tag, " R1 period"}, 32'(period_o), 32'hFFFF);
    chk({tag, " R1 count"}, 32'(wd_count_o), 0);
    chk({tag, " R1 nmi"}, 32'(nmi_o), 0);
    chk({tag, " R1 rst_req"}, 32'(rst_req_o), 0);
  endtask

  typedef struct packed {
    logic        wr;
    logic [1:0]  sel;
    logic [31:0] data;
    logic [5:0]  src;
    logic [6:0]  ef;
    logic [6:0]  es;
  } vec_t;

  localparam vec_t VEC [11] = '{
    '{1'b0, 2'd0, 32'h0000_0000, 6'h01, 7'h02, 7'h02}, // R2 source latch
    '{1'b0, 2'd0, 32'h0000_0000, 6'h00, 7'h02, 7'h02}, // R2 held
    '{1'b1, 2'd0, 32'h1234_007F, 6'h00, 7'h02, 7'h02}, // R11 bad clear key
    '{1'b1, 2'd0, 32'h5674_0002, 6'h00, 7'h00, 7'h02}, // R3 R8 clear
    '{1'b1, 2'd1, 32'h2732_0028, 6'h00, 7'h28, 7'h2A}, // R4 force
    '{1'b1, 2'd1, 32'h5674_0001, 6'h00, 7'h28, 7'h2A}, // R11 bad force key
    '{1'b1, 2'd2, 32'h6789_0001, 6'h00, 7'h28, 7'h2A}, // R5 enable
    '{1'b0, 2'd0, 32'h0000_0000, 6'h00, 7'h29, 7'h2B}, // R7 summary
    '{1'b1, 2'd0, 32'h5674_007F, 6'h04, 7'h09, 7'h2B}, // R12 set beats clear
    '{1'b1, 2'd0, 32'h5674_007F, 6'h00, 7'h01, 7'h2B}, // R12 summary re-set
    '{1'b1, 2'd0, 32'h5674_0001, 6'h00, 7'h00, 7'h2B}  // R7 R8 summary clear
  };

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired act=hung exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    check_reset("in reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    idle();
    check_reset("after reset");

    // table: R2 R3 R4 R5 R7 R8 R11 R12
    foreach (VEC[i]) begin
      cyc(VEC[i].wr, VEC[i].sel, VEC[i].data, VEC[i].src);
      chk($sformatf("vec %0d flags R2 R3 R4 R7 R12", i), 32'(flags_o), 32'(VEC[i].ef));
      chk($sformatf("vec %0d shadow R8", i), 32'(shadow_o), 32'(VEC[i].es));
      chk($sformatf("vec %0d nmi R7", i), 32'(nmi_o), 32'(VEC[i].ef[0]));
    end
    chk("R5 enable set", 32'(glb_en_o), 1);

    idle();
    chk("R9 counter zero when idle", 32'(wd_count_o), 0);

    cyc(1'b1, 2'd3, 32'h9238_0005, 6'h0);
    chk("R6 period load", 32'(period_o), 5);

    cyc(1'b1, 2'd1, 32'h2732_0002, 6'h0);
    idle();
    chk("R7 summary from forced source", 32'(nmi_o), 1);
    chk("R9 count at summary edge", 32'(wd_count_o), 0);
    for (int k = 1; k <= 4; k++) begin
      idle();
      chk("R9 counting", 32'(wd_count_o), 32'(k));
      chk("R10 no reset before period", 32'(rst_req_o), 0);
    end
    idle();
    chk("R10 reset at period", 32'(rst_req_o), 1);
    chk("R9 count at period", 32'(wd_count_o), 5);
    idle();
    chk("R9 count holds at period", 32'(wd_count_o), 5);
    chk("R10 reset held", 32'(rst_req_o), 1);

    cyc(1'b1, 2'd0, 32'h5674_007F, 6'h0);
    cyc(1'b1, 2'd0, 32'h5674_007F, 6'h0);
    chk("R3 all clear", 32'(flags_o), 0);
    chk("R10 reset drops with summary", 32'(rst_req_o), 0);
    idle();
    chk("R9 counter returns to zero", 32'(wd_count_o), 0);

    cyc(1'b1, 2'd3, 32'h1234_0002, 6'h0);
    chk("R11 bad period key", 32'(period_o), 5);

    cyc(1'b1, 2'd3, 32'h9238_FFFF, 6'h0);
    chk("R6 period reload", 32'(period_o), 32'hFFFF);
    cyc(1'b1, 2'd1, 32'h2732_0002, 6'h0);
    for (int k = 0; k < 12; k++) idle();
    chk("R10 no reset under large period", 32'(rst_req_o), 0);
    cyc(1'b1, 2'd3, 32'h9238_0003, 6'h0);
    chk("R10 period below count forces reset", 32'(rst_req_o), 1);
    cyc(1'b1, 2'd0, 32'h5674_007F, 6'h0);
    cyc(1'b1, 2'd0, 32'h5674_007F, 6'h0);

    cyc(1'b1, 2'd2, 32'h9238_0000, 6'h0);
    chk("R11 bad config key", 32'(glb_en_o), 1);
    cyc(1'b1, 2'd2, 32'h6789_0000, 6'h0);
    chk("R5 enable cleared", 32'(glb_en_o), 0);
    cyc(1'b0, 2'd0, 32'h0, 6'h20);
    idle();
    chk("R7 no summary while disabled", 32'(flags_o), 32'h40);
    chk("R7 nmi low while disabled", 32'(nmi_o), 0);
    chk("R8 shadow keeps history", 32'(shadow_o), 32'h6B);

    rst_ni = 1'b0;
    #1;
    check_reset("mid-run");
    @(negedge clk_i);
    rst_ni = 1'b1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule